// File: doc/BRIEF.md
# Clock Divider and Power-Mode Controller

The block turns a fast system clock into a core clock enable by dividing by a programmable power of two. It also selects where the core timing comes from: the PLL path, whose reference is either the internal oscillator or an external crystal, or a direct external clock input. A register-programmed operating mode decides which domains receive clocks: core, peripherals, PLL and oscillator.

When the PLL reports loss of lock, core timing stops at once and a sticky interrupt flag is raised. Core timing restarts by itself when lock returns. In the low-power modes, the four external interrupt lines can return the block to Active mode, and so can the wake-up timer while the oscillator still runs. Software programs the block through a small write port with three addresses.

Top module: `clkpm_ctrl`

## Requirements
- R1: After reset the divider setting is 3, the mode is Active, the reference is the internal oscillator and the lock flag is clear. The first `core_en` pulse comes 7 cycles after the cycle in which reset is released, and later pulses come every 8 cycles.
- R2: With the PLL path selected and lock present, `core_en` pulses once every 2^CD system clock cycles. CD is `wr_data[2:0]` written to address 1.
- R3: A new CD value takes effect only after the next pulse of the old period. Up to that pulse the old spacing is kept, and no shortened interval appears.
- R4: Mode is `wr_data[2:0]` written to address 0. The encodings and the domains they clock are: 000 Active (core, peripherals, PLL, oscillator); 001 Pause (peripherals, PLL, oscillator); 010 Nap (PLL, oscillator); 011 Sleep (oscillator only); 100 Stop (nothing).
- R5: Mode codes 101, 110 and 111 behave exactly as Active.
- R6: A pulse on any `irq_wake` line sets the mode to Active on the next clock edge. A `tmr_wake` pulse does the same only while the oscillator runs, so it has no effect in Stop.
- R7: While the PLL path is selected and `pll_lock` is low, `core_en` and `periph_en` stay low in the same cycle. Pulses resume once lock returns.
- R8: `lock_irq` is set on the edge after a cycle in which the PLL is on and `pll_lock` is low, and it holds until a write to address 2 with `wr_data[0]`=1. A write with `wr_data[0]`=0 leaves it set, and it is not set while the PLL is off.
- R9: Writing `wr_data[5:4]`=11 to address 1 makes `core_en` follow `ext_tick` directly, whatever the lock state. While this source is selected `clkout_en` stays low.
- R10: `wr_data[3]` at address 1 selects the PLL reference: 1 selects the internal oscillator and 0 selects the crystal, shown on `ref_xtal`. With the PLL path selected, `clkout_en` equals `core_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | fast system clock |
| rst_n | input | 1 | asynchronous active-low reset |
| wr_en | input | 1 | register write strobe |
| wr_addr | input | 2 | register address (0 mode, 1 clock config, 2 flag clear) |
| wr_data | input | 8 | write data |
| pll_lock | input | 1 | PLL lock indication |
| irq_wake | input | 4 | external interrupt wake lines |
| tmr_wake | input | 1 | wake-up timer event |
| ext_tick | input | 1 | external clock enable, already synchronised |
| core_en | output | 1 | core clock enable |
| periph_en | output | 1 | peripheral clock enable |
| pll_on | output | 1 | PLL domain powered |
| osc_on | output | 1 | oscillator and timer domain powered |
| ref_xtal | output | 1 | PLL reference is the crystal |
| clkout_en | output | 1 | drive the core clock on the output pin |
| lock_irq | output | 1 | sticky lock-loss interrupt |

## Verification
A register write lands on the edge that ends the write cycle. Its effect on the domain enables can therefore be seen at the next falling edge, and the bench samples there. Lock loss and `ext_tick` act on `core_en` within the same cycle, so the bench samples those a time step after it drives them. The lock flag and wake requests each take exactly one edge to act. Divider periods are measured from one pulse to the next after a settling period has passed. A new divider value is checked cycle by cycle against the old spacing up to the first boundary.

// File: rtl/clkpm_ctrl.sv
module clkpm_ctrl #(
  parameter int CDW = 3,
  parameter int MW  = 3,
  parameter logic [CDW-1:0] CD_RST = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic       pll_lock,
  input  logic [3:0] irq_wake,
  input  logic       tmr_wake,
  input  logic       ext_tick,
  output logic       core_en,
  output logic       periph_en,
  output logic       pll_on,
  output logic       osc_on,
  output logic       ref_xtal,
  output logic       clkout_en,
  output logic       lock_irq
);
  localparam int CNTW = (1 << CDW) - 1;

  logic [MW-1:0]   mode_q;
  logic [CDW-1:0]  cd_q, cd_act;
  logic            osc_int_q;
  logic [1:0]      src_q;
  logic [CNTW-1:0] cnt_q;
  logic            irq_q;

  wire [CNTW-1:0] lim = CNTW'((1 << cd_act) - 1);
  wire div_tick = (cnt_q == lim);

  wire m_pause = (mode_q == MW'(1));
  wire m_nap   = (mode_q == MW'(2));
  wire m_sleep = (mode_q == MW'(3));
  wire m_stop  = (mode_q == MW'(4));
  wire m_act   = !(m_pause || m_nap || m_sleep || m_stop);

  wire src_ext = (src_q == 2'b11);
  wire base    = src_ext ? ext_tick : (div_tick && pll_lock);

  assign core_en   = m_act && base;
  assign periph_en = (m_act || m_pause) && base;
  assign pll_on    = m_act || m_pause || m_nap;
  assign osc_on    = !m_stop;
  assign ref_xtal  = !osc_int_q;
  assign clkout_en = core_en && !src_ext;
  assign lock_irq  = irq_q;

  wire wake   = (|irq_wake) || (tmr_wake && osc_on);
  wire wr_mode = wr_en && (wr_addr == 2'd0);
  wire wr_cfg  = wr_en && (wr_addr == 2'd1);
  wire wr_clr  = wr_en && (wr_addr == 2'd2) && wr_data[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
    end else if (wake) begin
      mode_q <= '0;
    end else if (wr_mode) begin
      mode_q <= wr_data[MW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cd_q      <= CD_RST;
      osc_int_q <= 1'b1;
      src_q     <= 2'b00;
    end else if (wr_cfg) begin
      cd_q      <= wr_data[CDW-1:0];
      osc_int_q <= wr_data[3];
      src_q     <= wr_data[5:4];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      cd_act <= CD_RST;
    end else if (div_tick) begin
      cnt_q  <= '0;
      cd_act <= cd_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else if (pll_on && !pll_lock) begin
      irq_q <= 1'b1;
    end else if (wr_clr) begin
      irq_q <= 1'b0;
    end
  end
endmodule

module clkpm_ctrl_chk #(
  parameter int CDW = 3,
  parameter int MW  = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           wr_en,
  input logic [1:0]     wr_addr,
  input logic [7:0]     wr_data,
  input logic           pll_lock,
  input logic [3:0]     irq_wake,
  input logic           core_en,
  input logic           periph_en,
  input logic           osc_on,
  input logic           clkout_en,
  input logic           lock_irq,
  input logic [MW-1:0]  mode_q,
  input logic [1:0]     src_q,
  input logic [CDW-1:0] cd_act,
  input logic           div_tick
);
  // R7
  core_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (core_en && src_q != 2'b11) |-> pll_lock);
  // R6
  wake_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_wake) |=> (mode_q == '0));
  // R8
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_irq && !(wr_en && wr_addr == 2'd2 && wr_data[0])) |=> lock_irq);
  // R9
  clkout_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clkout_en |-> (src_q != 2'b11));
  // R3
  cd_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !div_tick |=> $stable(cd_act));
  // R4
  stop_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MW'(4)) |-> (!osc_on && !periph_en && !core_en));
endmodule

bind clkpm_ctrl clkpm_ctrl_chk #(.CDW(CDW), .MW(MW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .pll_lock(pll_lock), .irq_wake(irq_wake), .core_en(core_en), .periph_en(periph_en),
  .osc_on(osc_on), .clkout_en(clkout_en), .lock_irq(lock_irq), .mode_q(mode_q),
  .src_q(src_q), .cd_act(cd_act), .div_tick(div_tick)
);

// File: tb/clkpm_ctrl_bench.sv
module clkpm_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, pll_lock = 1'b1, tmr_wake = 1'b0, ext_tick = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [3:0] irq_wake = '0;
  logic core_en, periph_en, pll_on, osc_on, ref_xtal, clkout_en, lock_irq;
  int nchk = 0, nfail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clkpm_ctrl u_clkpm_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pll_lock(pll_lock), .irq_wake(irq_wake), .tmr_wake(tmr_wake), .ext_tick(ext_tick),
    .core_en(core_en), .periph_en(periph_en), .pll_on(pll_on), .osc_on(osc_on),
    .ref_xtal(ref_xtal), .clkout_en(clkout_en), .lock_irq(lock_irq)
  );

  task automatic check(string tag, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  // {core, periph, pll, osc} per mode code
  function automatic logic [3:0] dom_exp(int m);
    case (m)
      1: return 4'b0111;
      2: return 4'b0011;
      3: return 4'b0001;
      4: return 4'b0000;
      default: return 4'b1111;
    endcase
  endfunction

  task automatic meas(output int p);
    int g = 0;
    while (!core_en && g < 400) begin @(negedge clk); g++; end
    p = 0;
    do begin @(negedge clk); p++; end while (!core_en && p < 400);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
  endtask

  initial begin
    #(CLK_PERIOD*100000);
    nfail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    int first, p;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1 lock_irq", lock_irq, 0);
    check("R1 pll_on", pll_on, 1);
    check("R1 osc_on", osc_on, 1);
    check("R1 ref_xtal", ref_xtal, 0);
    first = -1;
    for (int i = 1; i <= 10; i++) begin
      @(negedge clk);
      if (core_en && first < 0) first = i;
    end
    check("R1 first pulse", first, 7);
    meas(p);
    check("R1 default period", p, 8);

    // R2 random dividers
    for (int k = 0; k < 8; k++) begin
      int cd = $urandom % 8;
      wr(2'd1, {4'b0000, 1'b1, 3'(cd)});
      meas(p); meas(p);
      check($sformatf("R2 period cd=%0d", cd), p, 1 << cd);
    end

    // R3 change at boundary
    wr(2'd1, 8'h0B);
    meas(p); meas(p);
    while (!core_en) @(negedge clk);
    @(negedge clk);
    wr(2'd1, 8'h08);
    for (int i = 2; i <= 10; i++) begin
      check($sformatf("R3 cycle %0d", i), core_en, (i >= 8) ? 1 : 0);
      @(negedge clk);
    end

    // R4 R5 modes, cd=0 so every cycle is a pulse
    repeat (4) @(negedge clk);
    for (int k = 0; k < 16; k++) begin
      int m = (k < 8) ? k : int'($urandom % 8);
      logic [3:0] e = dom_exp(m);
      wr(2'd0, 8'(m));
      for (int c = 0; c < 3; c++) begin
        check($sformatf("%s mode %0d core", m > 4 ? "R5" : "R4", m), core_en, e[3]);
        check($sformatf("%s mode %0d periph", m > 4 ? "R5" : "R4", m), periph_en, e[2]);
        check($sformatf("%s mode %0d pll", m > 4 ? "R5" : "R4", m), pll_on, e[1]);
        check($sformatf("%s mode %0d osc", m > 4 ? "R5" : "R4", m), osc_on, e[0]);
        @(negedge clk);
      end
    end

    // R6 wake behaviour
    wr(2'd0, 8'd4);
    tmr_wake = 1'b1; @(negedge clk); tmr_wake = 1'b0;
    check("R6 timer ignored in stop", osc_on, 0);
    check("R6 timer ignored in stop core", core_en, 0);
    irq_wake = 4'(1 << ($urandom % 4)); @(negedge clk); irq_wake = '0;
    check("R6 irq wakes from stop", core_en, 1);
    wr(2'd0, 8'd3);
    tmr_wake = 1'b1; @(negedge clk); tmr_wake = 1'b0;
    check("R6 timer wakes from sleep", pll_on, 1);
    check("R6 timer wakes core", core_en, 1);

    // R7 R8 lock loss
    pll_lock = 1'b0; #1;
    check("R7 core halted at once", core_en, 0);
    check("R7 periph halted", periph_en, 0);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check("R7 core stays halted", core_en, 0);
    end
    check("R8 flag set", lock_irq, 1);
    pll_lock = 1'b1;
    @(negedge clk);
    check("R7 core resumes", core_en, 1);
    check("R8 flag sticky", lock_irq, 1);
    wr(2'd2, 8'h00);
    check("R8 zero write keeps flag", lock_irq, 1);
    wr(2'd2, 8'h01);
    check("R8 clear", lock_irq, 0);
    wr(2'd0, 8'd3);
    pll_lock = 1'b0;
    repeat (4) @(negedge clk);
    check("R8 no flag with pll off", lock_irq, 0);
    pll_lock = 1'b1;
    irq_wake = 4'b1000; @(negedge clk); irq_wake = '0;
    check("R8 still clear after wake", lock_irq, 0);

    // R9 external clock
    wr(2'd1, 8'h38);
    for (int i = 0; i < 30; i++) begin
      ext_tick = 1'($urandom);
      if (i == 10) pll_lock = 1'b0;
      if (i == 20) pll_lock = 1'b1;
      #1;
      check("R9 core follows ext", core_en, ext_tick);
      check("R9 clkout off", clkout_en, 0);
      @(negedge clk);
    end
    ext_tick = 1'b0;
    wr(2'd2, 8'h01);

    // R10 crystal reference
    wr(2'd1, 8'h00);
    check("R10 ref_xtal", ref_xtal, 1);
    repeat (2) @(negedge clk);
    check("R10 clkout core", clkout_en, core_en);
    check("R10 clkout high", clkout_en, 1);
    wr(2'd1, 8'h08);
    check("R10 ref internal", ref_xtal, 0);

    summary();
    $finish;
  end
endmodule